// File: doc/BRIEF.md
# Inbound Bus-Master Address Window Translator

This block sits on the receive side of a host bridge. A bus master on the expansion bus presents an address. The block decides whether one of three programmable inbound windows claims that address. When a window claims it, the block outputs the matching 64-bit local memory address. Each window always starts at bus address zero. Its length comes from a 64-bit size word, and it adds a 64-bit local base to the incoming offset.

Software programs the windows through a 32-bit register port. Each 64-bit field is split into a low word and a high word. The middle window's size word has only a low word, and its high half behaves as all ones.

The address decode for ordinary bus memory happens elsewhere and arrives here as a hit flag. That region outranks the windows, so a bus-memory hit cancels any window claim. Where windows overlap, the lowest-numbered window wins. Each request gets its result one clock later.

Top module: `inbound_win_xlate`

## Requirements
- R1: After reset every size word reads as low word 0x00000000 and high word 0xFFFFFFFF, every local base reads zero, and all windows are disabled.
- R2: The register offsets are as follows. Size words are at 0x98/0xF8 for window 0 (low/high), 0xA4 for window 1 (low only) and 0xB0/0xFC for window 2. Local bases are at 0x9C/0xA0, 0xA8/0xAC and 0xB4/0xB8 (low/high). A write to one half leaves the other half unchanged. Writes to any other offset change nothing, and reads of any other offset return zero.
- R3: A window claims addresses only while bit 0 of its size word is 1.
- R4: A window's span is 2^64 minus the size word with bits 2:0 cleared, taken modulo 2^64. A masked size word of zero gives a span of the whole 2^64 space. Bits 1 and 2 have no effect.
- R5: An enabled window claims bus address A when A is below its span, and the result is local base + A modulo 2^64.
- R6: Window 1's size high word is fixed at 0xFFFFFFFF, so writing 0x00000001 at 0xA4 gives a span of exactly 2^32.
- R7: When several windows claim an address, the lowest-numbered one is reported on rsp_win (0, 1 or 2).
- R8: When req_bus_mem_hit is 1, no window claim is reported for that request.
- R9: rsp_valid is 1 exactly one cycle after a cycle with req_valid at 1, and rsp_hit is 1 only together with rsp_valid. A register write takes effect for a request presented in the next cycle.
- R10: When rsp_hit is 0, rsp_win and rsp_laddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Incoming bus-master address is valid |
| req_addr | input | 64 | Incoming bus-master address |
| req_bus_mem_hit | input | 1 | Address already claimed by bus memory |
| rsp_valid | output | 1 | Result for the previous cycle's request |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_win | output | 2 | Index of the claiming window |
| rsp_laddr | output | 64 | Translated local address |

## Verification
The bench probes each span at its last covered address and at the first address past it. A wrong two's-complement or mask step shows up there as an off-by-one or off-by-eight claim. It sets bits 1 and 2 of a size word, gives window 1 a span of exactly 2^32, and clears a masked size to zero to cover the whole space with a base that wraps. A design that forgets the fixed-ones high half, or that lets the low bits leak into the size, claims the wrong range. Overlapping windows, a bus-memory hit on a covered address, and a request issued right after a write would show a wrong priority, a missing override, or a configuration update applied one cycle late. Half-word writes followed by reads of the other half catch a write that clobbers the full 64 bits.

// File: rtl/iwx_pkg.sv
package iwx_pkg;
  localparam int NWIN = 3;
  localparam int AW   = 64;
  localparam int DW   = 32;
  localparam int RAW  = 8;
  localparam int WIDX = $clog2(NWIN);

  // Register offsets per window; the index is the window number.
  localparam logic [RAW-1:0] OFF_SZ_LO [NWIN] = '{8'h98, 8'hA4, 8'hB0};
  localparam logic [RAW-1:0] OFF_SZ_HI [NWIN] = '{8'hF8, 8'h00, 8'hFC};
  localparam logic [RAW-1:0] OFF_BS_LO [NWIN] = '{8'h9C, 8'hA8, 8'hB4};
  localparam logic [RAW-1:0] OFF_BS_HI [NWIN] = '{8'hA0, 8'hAC, 8'hB8};
  localparam bit           HAS_SZ_HI [NWIN] = '{1'b1, 1'b0, 1'b1};

  localparam logic [DW-1:0] SZ_HI_RST = '1;
  localparam logic [AW-1:0] SZ_MASK   = ~{{(AW-3){1'b0}}, 3'b111};

  typedef struct packed {
    logic [AW-1:0] sz;
    logic [AW-1:0] base;
  } win_cfg_t;
endpackage

// File: rtl/iwx_regs.sv
module iwx_regs
  import iwx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [RAW-1:0]        addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output win_cfg_t [NWIN-1:0]   cfg
);
  logic [NWIN-1:0][DW-1:0] rd_part;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [DW-1:0] sz_lo_q, bs_lo_q, bs_hi_q, sz_hi_v;
    logic          sz_lo_en, bs_lo_en, bs_hi_en;
    logic [DW-1:0] rd_w;

    assign sz_lo_en = wr && (addr == OFF_SZ_LO[g]);
    assign bs_lo_en = wr && (addr == OFF_BS_LO[g]);
    assign bs_hi_en = wr && (addr == OFF_BS_HI[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sz_lo_q <= '0;
      else if (sz_lo_en) sz_lo_q <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bs_lo_q <= '0;
      else if (bs_lo_en) bs_lo_q <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bs_hi_q <= '0;
      else if (bs_hi_en) bs_hi_q <= wdata;
    end

    if (HAS_SZ_HI[g]) begin : g_hi
      logic [DW-1:0] sz_hi_q;
      logic          sz_hi_en;
      assign sz_hi_en = wr && (addr == OFF_SZ_HI[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sz_hi_q <= SZ_HI_RST;
        else if (sz_hi_en) sz_hi_q <= wdata;
      end
      assign sz_hi_v = sz_hi_q;
    end else begin : g_fixed
      assign sz_hi_v = SZ_HI_RST;
    end

    always_comb begin
      rd_w = '0;
      if (addr == OFF_SZ_LO[g]) rd_w = sz_lo_q;
      if (addr == OFF_BS_LO[g]) rd_w = bs_lo_q;
      if (addr == OFF_BS_HI[g]) rd_w = bs_hi_q;
      if (HAS_SZ_HI[g] && (addr == OFF_SZ_HI[g])) rd_w = sz_hi_v;
    end

    assign rd_part[g]   = rd_w;
    assign cfg[g].sz    = {sz_hi_v, sz_lo_q};
    assign cfg[g].base  = {bs_hi_q, bs_lo_q};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NWIN; i++) rdata = rdata | rd_part[i];
  end
endmodule

// File: rtl/iwx_match.sv
module iwx_match
  import iwx_pkg::*;
(
  input  win_cfg_t        cfg,
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [AW-1:0]   laddr
);
  logic [AW-1:0] masked;
  logic [AW:0]   span;

  assign masked = cfg.sz & SZ_MASK;
  // Span is 2^AW - masked, held in AW+1 bits so a zero mask yields 2^AW.
  assign span   = {1'b0, ~masked} + {{AW{1'b0}}, 1'b1};
  assign hit    = cfg.sz[0] && ({1'b0, addr} < span);
  assign laddr  = cfg.base + addr;
endmodule

// File: rtl/iwx_prio.sv
module iwx_prio
  import iwx_pkg::*;
(
  input  logic [NWIN-1:0]           hit,
  input  logic [NWIN-1:0][AW-1:0]   laddr,
  output logic                      any,
  output logic [WIDX-1:0]           idx,
  output logic [AW-1:0]             sel_laddr
);
  always_comb begin
    any       = 1'b0;
    idx       = '0;
    sel_laddr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any       = 1'b1;
        idx       = WIDX'(i);
        sel_laddr = laddr[i];
      end
    end
  end
endmodule

// File: rtl/inbound_win_xlate.sv
module inbound_win_xlate
  import iwx_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_bus_mem_hit,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WIDX-1:0]  rsp_win,
  output logic [AW-1:0]    rsp_laddr
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[RST_STAGES-1];

  win_cfg_t [NWIN-1:0]       cfg;
  logic [NWIN-1:0]           win_hit;
  logic [NWIN-1:0][AW-1:0]   win_laddr;
  logic                      any_hit;
  logic [WIDX-1:0]           sel_idx;
  logic [AW-1:0]             sel_laddr;

  iwx_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n_q),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_match
    iwx_match u_match (
      .cfg   (cfg[g]),
      .addr  (req_addr),
      .hit   (win_hit[g]),
      .laddr (win_laddr[g])
    );
  end

  iwx_prio u_prio (
    .hit       (win_hit),
    .laddr     (win_laddr),
    .any       (any_hit),
    .idx       (sel_idx),
    .sel_laddr (sel_laddr)
  );

  // Next-state for the response stage.
  logic            valid_d, hit_d;
  logic [WIDX-1:0] win_d;
  logic [AW-1:0]   laddr_d;
  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && !req_bus_mem_hit && any_hit;
    win_d   = hit_d ? sel_idx   : '0;
    laddr_d = hit_d ? sel_laddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_laddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_win   <= win_d;
      rsp_laddr <= laddr_d;
    end
  end
endmodule

// File: rtl/iwx_checker.sv
module iwx_checker
  import iwx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_bus_mem_hit,
  input  logic             rsp_valid,
  input  logic             rsp_hit,
  input  logic [WIDX-1:0]  rsp_win,
  input  logic [AW-1:0]    rsp_laddr
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R9
  AST_BUS_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bus_mem_hit) |=> !rsp_hit); // R8
  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_win == '0 && rsp_laddr == '0)); // R10
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NWIN)); // R7
endmodule

bind inbound_win_xlate iwx_checker u_iwx_checker (
  .clk             (clk),
  .rst_n           (rst_n_q),
  .req_valid       (req_valid),
  .req_bus_mem_hit (req_bus_mem_hit),
  .rsp_valid       (rsp_valid),
  .rsp_hit         (rsp_hit),
  .rsp_win         (rsp_win),
  .rsp_laddr       (rsp_laddr)
);

// File: tb/inbound_win_xlate_bench.sv
`timescale 1ns/1ps
module inbound_win_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        req_bus_mem_hit;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_win;
  logic [63:0] rsp_laddr;

  always #2.5 clk = ~clk;

  inbound_win_xlate u_inbound_win_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_bus_mem_hit(req_bus_mem_hit),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_laddr(rsp_laddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Bench-side model of the register state, from the requirements.
  logic [63:0] m_sz [3];
  logic [63:0] m_bs [3];

  function automatic void model_reset();
    for (int i = 0; i < 3; i++) begin
      m_sz[i] = 64'hFFFF_FFFF_0000_0000;
      m_bs[i] = '0;
    end
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h98: m_sz[0][31:0]  = d;
      8'hF8: m_sz[0][63:32] = d;
      8'hA4: m_sz[1][31:0]  = d;
      8'hB0: m_sz[2][31:0]  = d;
      8'hFC: m_sz[2][63:32] = d;
      8'h9C: m_bs[0][31:0]  = d;
      8'hA0: m_bs[0][63:32] = d;
      8'hA8: m_bs[1][31:0]  = d;
      8'hAC: m_bs[1][63:32] = d;
      8'hB4: m_bs[2][31:0]  = d;
      8'hB8: m_bs[2][63:32] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h98: return m_sz[0][31:0];
      8'hF8: return m_sz[0][63:32];
      8'hA4: return m_sz[1][31:0];
      8'hB0: return m_sz[2][31:0];
      8'hFC: return m_sz[2][63:32];
      8'h9C: return m_bs[0][31:0];
      8'hA0: return m_bs[0][63:32];
      8'hA8: return m_bs[1][31:0];
      8'hAC: return m_bs[1][63:32];
      8'hB4: return m_bs[2][31:0];
      8'hB8: return m_bs[2][63:32];
      default: return 32'h0;
    endcase
  endfunction

  typedef struct {
    logic        hit;
    logic [1:0]  win;
    logic [63:0] laddr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic exp_t model_xlate(input logic [63:0] a, input logic bmh,
                                       input string tag);
    exp_t e;
    e.hit = 1'b0; e.win = '0; e.laddr = '0; e.tag = tag;
    if (!bmh) begin
      for (int i = 2; i >= 0; i--) begin
        logic [63:0] sz;
        logic [64:0] span;
        sz   = m_sz[i] & ~64'h7;
        span = (sz == 0) ? 65'h1_0000_0000_0000_0000 : (65'h1_0000_0000_0000_0000 - {1'b0, sz});
        if (m_sz[i][0] && ({1'b0, a} < span)) begin
          e.hit = 1'b1; e.win = 2'(i); e.laddr = m_bs[i] + a;
        end
      end
    end
    return e;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    model_write(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata === model_read(a), tag, 64'(reg_rdata), 64'(model_read(a)));
  endtask

  task automatic send(input logic [63:0] a, input logic bmh, input string tag);
    @(negedge clk);
    reg_wr = 1'b0;
    req_valid = 1'b1; req_addr = a; req_bus_mem_hit = bmh;
    sb_q.push_back(model_xlate(a, bmh, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0; req_valid = 1'b0;
    end
  endtask

  // Monitor: compare each response with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", 64'(rsp_valid), 64'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_hit === e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
        check(rsp_win === e.win, {e.tag, " win"}, 64'(rsp_win), 64'(e.win));
        check(rsp_laddr === e.laddr, {e.tag, " laddr"}, rsp_laddr, e.laddr);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [7:0] ALL_REGS [12] =
    '{8'h98, 8'hF8, 8'hA4, 8'hB0, 8'hFC, 8'h9C, 8'hA0, 8'hA8, 8'hAC, 8'hB4, 8'hB8, 8'hC0};

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_bus_mem_hit = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset values
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    for (int i = 0; i < 12; i++) rd(ALL_REGS[i], "R1 reset register");
    reg_addr = 8'hF8; #1;
    check(reg_rdata === 32'hFFFF_FFFF, "R1 size high reset", 64'(reg_rdata), 64'hFFFF_FFFF);
    send(64'h1234, 1'b0, "R3 all disabled after reset");

    // R3 R4 R5: window 0 of 64 KiB at local 0x1_0000_0000
    wr(8'h98, 32'hFFFF_0001);
    wr(8'hA0, 32'h0000_0001);
    send(64'h1234, 1'b0, "R9 R5 window0 right after write");
    send(64'hFFFF, 1'b0, "R4 last covered address");
    send(64'h1_0000, 1'b0, "R4 first uncovered address");
    send(64'h1234, 1'b1, "R8 bus memory overrides");
    wr(8'h98, 32'hFFFF_0007);
    send(64'hFFFF, 1'b0, "R4 low bits ignored inside");
    send(64'h1_0000, 1'b0, "R4 low bits ignored outside");

    // R7: window 1 overlaps window 0
    wr(8'hA4, 32'hFFF0_0001);
    wr(8'hA8, 32'h2000_0000);
    send(64'h1234, 1'b0, "R7 lowest window wins");
    send(64'h2_0000, 1'b0, "R5 window1 translate");
    send(64'hF_FFFF, 1'b0, "R4 window1 last");
    send(64'h10_0000, 1'b0, "R4 window1 past end");

    // R6: window 1 high half fixed at ones
    wr(8'hA4, 32'h0000_0001);
    rd(8'hA4, "R6 window1 size readback");
    send(64'hFFFF_FFFF, 1'b0, "R6 span is 2^32 last");
    send(64'h1_0000_0000, 1'b0, "R6 span is 2^32 past end");

    // R2: half writes keep the other half
    wr(8'hA0, 32'h0000_0005);
    rd(8'h9C, "R2 base low kept");
    rd(8'hA0, "R2 base high written");

    // Window 2 with a 64-bit size word
    wr(8'hFC, 32'hFFFF_FFFE);
    wr(8'hB0, 32'h0000_0001);
    wr(8'hB4, 32'hFFFF_F000);
    rd(8'hFC, "R2 size high written");
    send(64'h1_8000_0000, 1'b0, "R5 window2 translate");
    send(64'h2_0000_0000, 1'b0, "R4 window2 past end");

    // R4: zero masked size covers the whole space, base wraps
    wr(8'hFC, 32'h0000_0000);
    wr(8'hB8, 32'h0000_0010);
    send(64'hFFFF_FFFF_FFFF_FFF0, 1'b0, "R4 R5 full space with wrap");

    // R3: disable window 0, window 1 takes over
    wr(8'h98, 32'hFFFF_0000);
    send(64'h1234, 1'b0, "R3 disabled window skipped");
    send(64'h1234, 1'b1, "R8 bus memory over window1");
    send(64'h5_0000_0000, 1'b0, "R7 only window2 covers");

    // R2: unmapped write is ignored
    wr(8'hC0, 32'hDEAD_BEEF);
    for (int i = 0; i < 12; i++) rd(ALL_REGS[i], "R2 state after unmapped write");
    send(64'h1234, 1'b0, "R2 translation after unmapped write");

    idle(4);
    check(sb_q.size() == 0, "R9 all responses seen", 64'(sb_q.size()), 64'h0);
    check(rsp_valid === 1'b0, "R9 idle no response", 64'(rsp_valid), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule